// File: doc/BRIEF.md
# Multiplexed Segment LCD Pin Controller

This block decides, cycle by cycle, what every common and segment pin of a multiplexed segment LCD should do: stay high impedance, drive the ground level, or carry one of four encoded drive levels. It holds one byte of display memory per segment and a small register set. The registers are a per-segment enable mask, the active-common count with a time-slot length select, a bias-on bit with a programmable settling delay, and a two-bit display mode. All of them are loaded through a simple byte write port. The pin outputs are level codes. An external analog stage turns each code into a voltage.

Each pin passes through three phases. After reset it is high impedance. Once it is configured, by its enable bit for a segment or by the common count for a common, it drives ground. Once a display mode is selected and the bias has settled, it carries the scanned waveform. The commons are scanned in ascending order, one per time slot. The drive polarity is inverted on alternate frames, so the average drive on each pixel is zero. If a display mode is requested while the bias delay is still counting, the waveform starts on the first cycle after the delay has expired.

Top module: `lcd_mux_ctrl`

## Requirements
- R1: After reset, and while rst_n is low, every com_oe and seg_oe bit is 0 and every level code is 00. Reset clears the bias bit, the mode, the common count and the enable mask.
- R2: Segment i drives its pin (seg_oe[i]=1) exactly when its enable bit is 1. Enable byte n is written at address 0x88+n, and bit b of that byte belongs to segment 8n+b. A segment that is not enabled stays high impedance with code 00 in every mode.
- R3: Bits [3:0] of address 0x80 give the number of active commons. Values above 8 are taken as 8. Common k drives its pin when k is less than that count and is otherwise high impedance. Bits [5:4] of the same address give a select F, and each common time slot lasts 2^(F+1) clock cycles.
- R4: Bit 0 of address 0x81 turns the bias on, and address 0x82 holds a delay D. The bias is ready D cycles after the edge that writes the bias bit to 1. Before that, every pin code is 00. A mode requested earlier starts on the first ready cycle. Clearing the bias bit returns all pins to 00 at once and restarts the delay.
- R5: Level codes are 00 = ground, 01 = VL1, 10 = VL2 and 11 = VL3. A configured pin drives 00 while the mode is 00 or the bias is not ready.
- R6: Bits [1:0] of address 0x83 select the mode: 00 ground only, 01 segments follow display memory, 10 all segments off, 11 all segments on.
- R7: The first cycle of display is slot 0. Slots run 0, 1, … up to count−1 and then wrap to 0, each lasting the slot length of R3. One pass over all slots is one frame.
- R8: In even frames, starting with the first, the selected common is 11, the other active commons are 01, an on segment is 00 and an off segment is 10. In odd frames the selected common is 00, the other active commons are 10, an on segment is 11 and an off segment is 01.
- R9: Address i (0 to 64) holds the byte for segment i. Bit k of that byte, where 1 means on, gives the segment's state while common k is selected.
- R10: Writing mode 00 returns configured pins to 00 and leaves display memory unchanged, so re-entering a display mode shows the same data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register and display memory write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| com_oe | output | 8 | Common pin drive enable, 0 = high impedance |
| com_lvl | output | 16 | Common level codes, common k at bits [2k+1:2k] |
| seg_oe | output | 65 | Segment pin drive enable, 0 = high impedance |
| seg_lvl | output | 130 | Segment level codes, segment i at bits [2i+1:2i] |

## Verification
The assertions check four things on every cycle: no pin leaves the ground code before the bias is ready, no segment drives without its enable bit, at most one common sits at the selected extreme level, and the polarity inverts whenever the slot wraps to zero. They also check that writing the mode register leaves display memory untouched. Only the bench's scenarios can show the exact cycle in which a deferred display starts. The same applies to the slot order and length for each slot select, the clamping of the common count, the data patterns of the three display modes, and the recovery of the waveform after the bias is turned off and on again.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

    localparam int ADDR_W    = 8;
    localparam int FRAME_LSB = 4;

    localparam logic [ADDR_W-1:0] ADR_DUTY  = 8'h80;
    localparam logic [ADDR_W-1:0] ADR_BIAS  = 8'h81;
    localparam logic [ADDR_W-1:0] ADR_DELAY = 8'h82;
    localparam logic [ADDR_W-1:0] ADR_MODE  = 8'h83;
    localparam logic [ADDR_W-1:0] ADR_MASK0 = 8'h88;

    typedef enum logic [1:0] {
        LVL_GND = 2'b00,
        LVL_V1  = 2'b01,
        LVL_V2  = 2'b10,
        LVL_V3  = 2'b11
    } lvl_e;

    typedef enum logic [1:0] {
        MODE_GND   = 2'b00,
        MODE_DATA  = 2'b01,
        MODE_BLANK = 2'b10,
        MODE_FILL  = 2'b11
    } mode_e;

endpackage

// File: rtl/lcd_regfile.sv
module lcd_regfile
    import lcd_pkg::*;
#(
    parameter int NUM_SEG = 65,
    parameter int NUM_COM = 8,
    parameter int DUTY_W  = 4,
    parameter int FRAME_W = 2,
    parameter int DLY_W   = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [7:0]             wr_data,
    output logic [NUM_SEG*8-1:0]   mem_flat,
    output logic [NUM_SEG-1:0]     seg_en,
    output logic [DUTY_W-1:0]      duty,
    output logic [FRAME_W-1:0]     frame,
    output logic                   bias_on,
    output logic [DLY_W-1:0]       dly,
    output mode_e                  mode
);

    localparam int SEG_IW     = $clog2(NUM_SEG);
    localparam int MASK_BYTES = (NUM_SEG + 7) / 8;

    typedef struct packed {
        logic [NUM_SEG-1:0][7:0] mem;
        logic [NUM_SEG-1:0]      seg_en;
        logic [DUTY_W-1:0]       duty;
        logic [FRAME_W-1:0]      frame;
        logic                    bias_on;
        logic [DLY_W-1:0]        dly;
        mode_e                   mode;
    } regs_t;

    regs_t st_d, st_q;
    logic [ADDR_W-1:0] moff;
    logic [3:0]        duty_req;

    always_comb begin
        st_d     = st_q;
        moff     = wr_addr - ADR_MASK0;
        duty_req = wr_data[3:0];
        if (wr_en) begin
            if (wr_addr < ADDR_W'(NUM_SEG)) begin
                st_d.mem[wr_addr[SEG_IW-1:0]] = wr_data;
            end else begin
                case (wr_addr)
                    ADR_DUTY: begin
                        st_d.duty  = (int'(duty_req) > NUM_COM) ? DUTY_W'(NUM_COM)
                                                                : DUTY_W'(duty_req);
                        st_d.frame = wr_data[FRAME_LSB +: FRAME_W];
                    end
                    ADR_BIAS:  st_d.bias_on = wr_data[0];
                    ADR_DELAY: st_d.dly     = wr_data[DLY_W-1:0];
                    ADR_MODE:  st_d.mode    = mode_e'(wr_data[1:0]);
                    default: begin
                        if (wr_addr >= ADR_MASK0 && moff < ADDR_W'(MASK_BYTES)) begin
                            for (int b = 0; b < 8; b++) begin
                                if (int'(moff) * 8 + b < NUM_SEG) begin
                                    st_d.seg_en[int'(moff) * 8 + b] = wr_data[b];
                                end
                            end
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_flat = st_q.mem;
    assign seg_en   = st_q.seg_en;
    assign duty     = st_q.duty;
    assign frame    = st_q.frame;
    assign bias_on  = st_q.bias_on;
    assign dly      = st_q.dly;
    assign mode     = st_q.mode;

    // R10: a mode write never disturbs display memory
    assert_mem_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADR_MODE) |=> $stable(st_q.mem))
        else $error("display memory changed by a mode write");

endmodule

// File: rtl/lcd_bias_timer.sv
module lcd_bias_timer #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bias_on,
    input  logic [DLY_W-1:0] dly,
    output logic             ready
);

    typedef struct packed {
        logic [DLY_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!bias_on) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != '1) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready = bias_on && (st_q.cnt >= dly);

endmodule

// File: rtl/lcd_scan.sv
module lcd_scan #(
    parameter int DUTY_W  = 4,
    parameter int SLOT_W  = 3,
    parameter int FRAME_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               active,
    input  logic [DUTY_W-1:0]  duty,
    input  logic [FRAME_W-1:0] frame,
    output logic [SLOT_W-1:0]  slot,
    output logic               pol
);

    localparam int PRE_W = 1 << FRAME_W;

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [SLOT_W-1:0] slot;
        logic              pol;
    } scan_t;

    scan_t st_d, st_q;
    logic [PRE_W:0]    span;
    logic [PRE_W:0]    last;
    logic [DUTY_W-1:0] eff_duty;
    logic [DUTY_W-1:0] slot_nxt;

    always_comb begin
        st_d     = st_q;
        span     = (PRE_W + 1)'(2) << frame;
        last     = span - 1'b1;
        eff_duty = (duty == '0) ? DUTY_W'(1) : duty;
        slot_nxt = DUTY_W'(st_q.slot) + 1'b1;
        if (!active) begin
            st_d = '0;
        end else if (DUTY_W'(st_q.slot) >= eff_duty) begin
            st_d.pre  = '0;
            st_d.slot = '0;
            st_d.pol  = ~st_q.pol;
        end else if ({1'b0, st_q.pre} == last) begin
            st_d.pre = '0;
            if (slot_nxt >= eff_duty) begin
                st_d.slot = '0;
                st_d.pol  = ~st_q.pol;
            end else begin
                st_d.slot = SLOT_W'(slot_nxt);
            end
        end else begin
            st_d.pre = st_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign slot = st_q.slot;
    assign pol  = st_q.pol;

    // R8: returning to slot 0 from a later slot starts a frame of opposite polarity
    assert_frame_flip_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && st_q.slot == '0 && $past(st_q.slot) != '0)
            |-> (st_q.pol != $past(st_q.pol)))
        else $error("polarity did not invert at frame wrap");

endmodule

// File: rtl/lcd_pin_encoder.sv
module lcd_pin_encoder
    import lcd_pkg::*;
#(
    parameter int NUM_COM = 8,
    parameter int NUM_SEG = 65,
    parameter int DUTY_W  = 4,
    parameter int SLOT_W  = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   active,
    input  mode_e                  mode,
    input  logic [SLOT_W-1:0]      slot,
    input  logic                   pol,
    input  logic [DUTY_W-1:0]      duty,
    input  logic [NUM_SEG-1:0]     seg_en,
    input  logic [NUM_SEG*8-1:0]   mem_flat,
    output logic [NUM_COM-1:0]     com_oe,
    output logic [2*NUM_COM-1:0]   com_lvl,
    output logic [NUM_SEG-1:0]     seg_oe,
    output logic [2*NUM_SEG-1:0]   seg_lvl
);

    logic [NUM_COM-1:0] com_ext;

    for (genvar k = 0; k < NUM_COM; k++) begin : g_com
        logic cfg_k;
        logic sel_k;
        lvl_e lvl_k;
        always_comb begin
            cfg_k = DUTY_W'(k) < duty;
            sel_k = SLOT_W'(k) == slot;
            if (!cfg_k || !active) begin
                lvl_k = LVL_GND;
            end else if (sel_k) begin
                lvl_k = pol ? LVL_GND : LVL_V3;
            end else begin
                lvl_k = pol ? LVL_V2 : LVL_V1;
            end
        end
        assign com_oe[k]          = cfg_k;
        assign com_lvl[2*k +: 2]  = lvl_k;
        assign com_ext[k]         = com_oe[k] && active &&
                                    (com_lvl[2*k +: 2] == (pol ? LVL_GND : LVL_V3));
    end

    for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
        logic [7:0] seg_byte;
        logic       on_i;
        lvl_e       lvl_i;
        always_comb begin
            seg_byte = mem_flat[i*8 +: 8];
            case (mode)
                MODE_FILL:  on_i = 1'b1;
                MODE_BLANK: on_i = 1'b0;
                default:    on_i = seg_byte[slot];
            endcase
            if (!seg_en[i] || !active) begin
                lvl_i = LVL_GND;
            end else if (!pol) begin
                lvl_i = on_i ? LVL_GND : LVL_V2;
            end else begin
                lvl_i = on_i ? LVL_V3 : LVL_V1;
            end
        end
        assign seg_oe[i]         = seg_en[i];
        assign seg_lvl[2*i +: 2] = lvl_i;
    end

    // R8: never more than one common at the selected extreme level
    assert_single_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(com_ext))
        else $error("more than one common selected");

endmodule

// File: rtl/lcd_mux_ctrl.sv
module lcd_mux_ctrl
    import lcd_pkg::*;
#(
    parameter int NUM_COM = 8,
    parameter int NUM_SEG = 65,
    parameter int FRAME_W = 2,
    parameter int DLY_W   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [7:0]           wr_addr,
    input  logic [7:0]           wr_data,
    output logic [NUM_COM-1:0]   com_oe,
    output logic [2*NUM_COM-1:0] com_lvl,
    output logic [NUM_SEG-1:0]   seg_oe,
    output logic [2*NUM_SEG-1:0] seg_lvl
);

    localparam int DUTY_W = $clog2(NUM_COM + 1);
    localparam int SLOT_W = (NUM_COM > 1) ? $clog2(NUM_COM) : 1;

    logic [NUM_SEG*8-1:0] mem_flat;
    logic [NUM_SEG-1:0]   seg_en;
    logic [DUTY_W-1:0]    duty;
    logic [FRAME_W-1:0]   frame;
    logic                 bias_on;
    logic [DLY_W-1:0]     dly;
    mode_e                mode;
    logic                 bias_ready;
    logic                 active;
    logic [SLOT_W-1:0]    slot;
    logic                 pol;

    lcd_regfile #(
        .NUM_SEG(NUM_SEG), .NUM_COM(NUM_COM), .DUTY_W(DUTY_W),
        .FRAME_W(FRAME_W), .DLY_W(DLY_W)
    ) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .mem_flat(mem_flat), .seg_en(seg_en), .duty(duty), .frame(frame),
        .bias_on(bias_on), .dly(dly), .mode(mode)
    );

    lcd_bias_timer #(.DLY_W(DLY_W)) i_bias (
        .clk(clk), .rst_n(rst_n), .bias_on(bias_on), .dly(dly), .ready(bias_ready)
    );

    assign active = (mode != MODE_GND) && bias_ready;

    lcd_scan #(.DUTY_W(DUTY_W), .SLOT_W(SLOT_W), .FRAME_W(FRAME_W)) i_scan (
        .clk(clk), .rst_n(rst_n), .active(active), .duty(duty), .frame(frame),
        .slot(slot), .pol(pol)
    );

    lcd_pin_encoder #(
        .NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG), .DUTY_W(DUTY_W), .SLOT_W(SLOT_W)
    ) i_enc (
        .clk(clk), .rst_n(rst_n), .active(active), .mode(mode), .slot(slot), .pol(pol),
        .duty(duty), .seg_en(seg_en), .mem_flat(mem_flat),
        .com_oe(com_oe), .com_lvl(com_lvl), .seg_oe(seg_oe), .seg_lvl(seg_lvl)
    );

    // R1: the first cycle out of reset has every pin at high impedance
    assert_reset_hiz_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (com_oe == '0 && seg_oe == '0))
        else $error("pin driven straight out of reset");

    // R4: no waveform level before the bias delay has expired
    assert_gnd_until_bias_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !bias_ready |-> (com_lvl == '0 && seg_lvl == '0))
        else $error("waveform before bias ready");

    // R2: a segment without its enable bit never drives
    assert_seg_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_oe & ~seg_en) == '0)
        else $error("segment driven without enable");

endmodule

// File: tb/test_lcd_mux_ctrl.sv
module test_lcd_mux_ctrl;

    localparam int NCOM = 8;
    localparam int NSEG = 65;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [NCOM-1:0]   com_oe;
    logic [2*NCOM-1:0] com_lvl;
    logic [NSEG-1:0]   seg_oe;
    logic [2*NSEG-1:0] seg_lvl;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    logic [NSEG-1:0] mask_m = '0;
    logic [7:0]      mem_m [NSEG];

    // entries: [7:6] mode, [5:4] slot select, [3:0] common count
    localparam logic [7:0] SCAN_TBL [5] = '{
        8'b01_00_0100, 8'b10_01_0011, 8'b11_00_0001, 8'b01_00_1000, 8'b01_10_0010
    };

    lcd_mux_ctrl i_lcd_mux_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .com_oe(com_oe), .com_lvl(com_lvl), .seg_oe(seg_oe), .seg_lvl(seg_lvl)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [255:0] got, input logic [255:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        if (a < 8'(NSEG)) mem_m[a] = d;
        if (a >= 8'h88 && a < 8'h91) begin
            for (int b = 0; b < 8; b++) begin
                if ((int'(a) - 'h88) * 8 + b < NSEG) mask_m[(int'(a) - 'h88) * 8 + b] = d[b];
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [2*NSEG-1:0] exp_seg(input int m, input int slot,
                                                   input int pol, input bit act);
        logic [2*NSEG-1:0] r;
        logic on;
        r = '0;
        for (int i = 0; i < NSEG; i++) begin
            on = (m == 3) ? 1'b1 : (m == 2) ? 1'b0 : mem_m[i][slot];
            if (mask_m[i] && act)
                r[2*i +: 2] = (pol == 0) ? (on ? 2'b00 : 2'b10) : (on ? 2'b11 : 2'b01);
        end
        return r;
    endfunction

    function automatic logic [2*NCOM-1:0] exp_com(input int duty, input int slot,
                                                   input int pol, input bit act);
        logic [2*NCOM-1:0] r;
        r = '0;
        for (int k = 0; k < duty; k++) begin
            if (act) begin
                if (k == slot) r[2*k +: 2] = (pol == 0) ? 2'b11 : 2'b00;
                else           r[2*k +: 2] = (pol == 0) ? 2'b01 : 2'b10;
            end
        end
        return r;
    endfunction

    // R7 R8 R9 R6: walk two frames and compare every pin at every cycle
    task automatic run_scan(input int m, input int duty, input int len);
        for (int j = 0; j < 2 * duty * len; j++) begin
            chk($sformatf("R7/R8 commons mode=%0d duty=%0d j=%0d", m, duty, j),
                com_lvl, exp_com(duty, (j / len) % duty, (j / (len * duty)) % 2, 1'b1));
            chk($sformatf("R9/R6 segments mode=%0d duty=%0d j=%0d", m, duty, j),
                seg_lvl, exp_seg(m, (j / len) % duty, (j / (len * duty)) % 2, 1'b1));
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NSEG; i++) mem_m[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk("R1 com_oe in reset", com_oe, '0);
        chk("R1 seg_oe in reset", seg_oe, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 seg_oe after reset", seg_oe, '0);
        chk("R1 levels after reset", {com_lvl, seg_lvl}, '0);
        chk("R3 no commons after reset", com_oe, '0);

        // display memory first: pins must stay high impedance
        wr(8'd0, 8'hA5); wr(8'd1, 8'h0F); wr(8'd2, 8'hFF);
        wr(8'd3, 8'h00); wr(8'd5, 8'hFF); wr(8'd64, 8'h3C);
        chk("R2 memory alone drives nothing", seg_oe, '0);

        wr(8'h88, 8'h0F); wr(8'h90, 8'h01);
        chk("R2 enabled segments drive", seg_oe, mask_m);
        chk("R5 enabled segments at ground", seg_lvl, '0);
        chk("R2 seg5 unmasked", seg_oe[5], 1'b0);

        wr(8'h80, 8'h04);
        chk("R3 four commons drive", com_oe, 8'h0F);
        chk("R5 commons at ground", com_lvl, '0);
        wr(8'h80, 8'h0C);
        chk("R3 count clamps to 8", com_oe, 8'hFF);
        wr(8'h80, 8'h04);

        // bias delay 10, mode requested one cycle after bias on
        wr(8'h82, 8'd10);
        wr(8'h81, 8'h01);
        wr(8'h83, 8'h01);
        repeat (8) @(negedge clk);
        chk("R4 still ground before delay", {com_lvl, seg_lvl}, '0);
        @(negedge clk);
        chk("R4 commons start on ready", com_lvl, exp_com(4, 0, 0, 1'b1));
        chk("R4 segments start on ready", seg_lvl, exp_seg(1, 0, 0, 1'b1));

        for (int t = 0; t < 5; t++) begin
            wr(8'h83, 8'h00);
            chk("R10 mode clear returns to ground", seg_lvl, '0);
            chk("R10 pins stay configured", seg_oe, mask_m);
            wr(8'h80, {2'b00, SCAN_TBL[t][5:4], SCAN_TBL[t][3:0]});
            wr(8'h83, {6'b0, SCAN_TBL[t][7:6]});
            run_scan(int'(SCAN_TBL[t][7:6]), int'(SCAN_TBL[t][3:0]),
                     2 << SCAN_TBL[t][5:4]);
        end

        // bias off during display, then on again with delay 3 (mode 01, two commons)
        wr(8'h81, 8'h00);
        chk("R4 bias off grounds pins", {com_lvl, seg_lvl}, '0);
        chk("R4 bias off keeps commons driven", com_oe, 8'h03);
        wr(8'h82, 8'd3);
        wr(8'h81, 8'h01);
        chk("R4 restart delay count 0", {com_lvl, seg_lvl}, '0);
        repeat (2) @(negedge clk);
        chk("R4 restart delay count 2", {com_lvl, seg_lvl}, '0);
        @(negedge clk);
        chk("R4 waveform after restart", com_lvl, exp_com(2, 0, 0, 1'b1));
        chk("R10 memory kept after restart", seg_lvl, exp_seg(1, 0, 0, 1'b1));

        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset mid display com", com_oe, '0);
        chk("R1 reset mid display seg", seg_oe, '0);
        chk("R1 reset mid display levels", {com_lvl, seg_lvl}, '0);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule